// File: doc/BRIEF.md
# Bus-Mapped Multiply, Divide and Shift Unit

This block is an unsigned arithmetic coprocessor that sits on a byte-wide register bus next to a small CPU. Software loads operands into six byte registers and the order of those writes both selects the operation and launches it. No opcode register exists. The unit then works on its own, one bit per clock, while the CPU carries on. When the busy output drops, the results have overwritten the operand registers.

Four operations are supported:
- 32-by-16 division, giving a quotient and a remainder.
- 16-by-16 multiplication, giving a 32-bit product.
- 32-bit logical shift in either direction.
- Normalize, which shifts left until the top bit is set and reports how many places it moved.

A seventh register holds the shift controls and two read-only flags. The overflow flag reports arithmetic exceptions. The error flag reports an operand register written while a calculation is still running.

Registers are selected by a 3-bit index:
- Indexes 0 to 5 are the operand bytes, called B0 to B5 below.
- Index 6 is the control register.

Reads are registered, so read data appears one clock after the read strobe.

Top module: `arith_copro`

## Requirements
- R1: After reset, all six operand bytes and the control register read 00h and busy is low.
- R2: Writing B0, B1, B2, B3 (dividend, low byte first) then B4, B5 (divisor, low byte first) starts a division on the B5 write. The quotient returns in B0..B3 and the remainder in B4..B5.
- R3: Division by zero sets the overflow flag (control bit 6). It returns quotient FFFFFFFFh and a remainder equal to the low 16 bits of the dividend.
- R4: Writing B0, B4, B1, B5 in that order multiplies {B1,B0} by {B5,B4}, starting on the B5 write. The product returns in B0..B3 (low byte in B0), and B4..B5 keep the multiplier.
- R5: A multiplication sets the overflow flag exactly when the product exceeds 0000FFFFh.
- R6: Writing B0..B3 then the control register with a nonzero count in bits 4:0 starts a logical shift of {B3,B2,B1,B0} by that count. Bit 5 selects the direction: 1 shifts right, 0 shifts left.
- R7: A control write with count 0 in that sequence starts a normalize: a left shift until bit 31 is 1, with the number of places written into bits 4:0. A zero operand gives count 31 and result 0.
- R8: A normalize started while B3 bit 7 is already 1 sets the overflow flag, leaves the value unchanged and gives count 0.
- R9: Any operand-byte write while busy sets the error flag (control bit 7). The written data is discarded and the running result is unaffected.
- R10: The error flag clears on an operand-byte read while not busy. Control bits 7:6 cannot be written.
- R11: Any write to B0 while not busy clears the overflow flag.
- R12: Busy is high in the cycle after the launching write and stays high for steps+2 cycles, where steps is:
  - 32 for division;
  - 16 for multiplication;
  - the count for a shift;
  - the leading-zero count for a normalize.
- R13: Writes that do not follow a launch order store their data but start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register index: 0-5 operand bytes, 6 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid one clock after rd_en |
| busy | output | 1 | High while an operation is launching, running or writing back |

## Verification
Busy rises immediately after the clock edge that takes the launching write. It then falls steps+2 edges later: 34 for division, 18 for multiplication, count+2 for shifts and leading-zeros+2 for normalize. The bench samples busy one time unit after each edge and counts edges until it drops, comparing that count against the value computed from the operation. Results and flags are fetched only once busy is low. Each read value is taken one time unit after the edge that registers it.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;
  localparam int CNT_W     = 5;
  localparam int NREG      = 6;
  localparam int IDX_CTRL  = 6;
  localparam int IDX_DLAST = 5;
  localparam int IDX_MLAST = 3;
  localparam int STEP_W    = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DIV,
    OP_MUL,
    OP_SHIFT,
    OP_NORM
  } op_e;
endpackage

// File: rtl/arith_seq.sv
module arith_seq
  import arith_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] idx,
  input  logic              cnt_zero,
  output logic              start,
  output op_e               op
);
  typedef enum logic [2:0] {S_IDLE, S_W0, S_D1, S_D2, S_D3, S_D4, S_M4, S_M1} st_e;

  st_e st_q, st_d;
  logic go;
  op_e kind;

  always_comb begin
    st_d = st_q;
    go   = 1'b0;
    kind = OP_NONE;
    if (wr_ok) begin
      st_d = S_IDLE;
      if (idx == ADDR_W'(0)) begin
        st_d = S_W0;
      end else begin
        case (st_q)
          S_W0: if (idx == ADDR_W'(1)) st_d = S_D1;
                else if (idx == ADDR_W'(4)) st_d = S_M4;
          S_D1: if (idx == ADDR_W'(2)) st_d = S_D2;
          S_D2: if (idx == ADDR_W'(3)) st_d = S_D3;
          S_D3: if (idx == ADDR_W'(4)) st_d = S_D4;
                else if (idx == ADDR_W'(IDX_CTRL)) begin
                  go   = 1'b1;
                  kind = cnt_zero ? OP_NORM : OP_SHIFT;
                end
          S_D4: if (idx == ADDR_W'(5)) begin
                  go   = 1'b1;
                  kind = OP_DIV;
                end
          S_M4: if (idx == ADDR_W'(1)) st_d = S_M1;
          S_M1: if (idx == ADDR_W'(5)) begin
                  go   = 1'b1;
                  kind = OP_MUL;
                end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      start <= 1'b0;
      op    <= OP_NONE;
    end else begin
      st_q  <= st_d;
      start <= go;
      if (go) op <= kind;
    end
  end
endmodule

// File: rtl/arith_engine.sv
module arith_engine
  import arith_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  op_e               op,
  input  logic              dir,
  input  logic [WORD_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  input  logic [STEP_W-1:0] steps,
  output logic              run,
  output logic              done,
  output logic [WORD_W-1:0] res_w,
  output logic [HALF_W-1:0] res_h
);
  logic [WORD_W-1:0] w_q;
  logic [HALF_W-1:0] h_q, rem_q, diff_lo;
  logic [HALF_W:0]   trial, acc;
  logic [STEP_W-1:0] cnt_q;
  logic              fits, dir_q;
  op_e               op_q;

  always_comb begin
    trial   = {rem_q, w_q[WORD_W-1]};
    fits    = trial >= {1'b0, h_q};
    diff_lo = trial[HALF_W-1:0] - h_q;
    acc     = {1'b0, w_q[WORD_W-1:HALF_W]} + (w_q[0] ? {1'b0, h_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      done  <= 1'b0;
      w_q   <= '0;
      h_q   <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
      op_q  <= OP_NONE;
    end else begin
      done <= 1'b0;
      if (load) begin
        w_q   <= (op == OP_MUL) ? {{HALF_W{1'b0}}, a[HALF_W-1:0]} : a;
        h_q   <= b;
        rem_q <= '0;
        op_q  <= op;
        dir_q <= dir;
        cnt_q <= steps;
        if (steps == '0) done <= 1'b1;
        else             run  <= 1'b1;
      end else if (run) begin
        case (op_q)
          OP_DIV: begin
            w_q   <= {w_q[WORD_W-2:0], fits};
            rem_q <= fits ? diff_lo : trial[HALF_W-1:0];
          end
          OP_MUL:   w_q <= {acc, w_q[HALF_W-1:1]};
          OP_SHIFT: w_q <= dir_q ? (w_q >> 1) : (w_q << 1);
          default:  w_q <= w_q << 1;
        endcase
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == STEP_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign res_w = w_q;
  assign res_h = (op_q == OP_DIV) ? rem_q : h_q;
endmodule

// File: rtl/arith_copro.sv
module arith_copro
  import arith_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int WBYTES = WORD_W / BYTE_W;
  localparam int HBYTES = HALF_W / BYTE_W;

  logic [BYTE_W-1:0] md [NREG];
  logic              err_q, ovf_q, dir_q, armed_q;
  logic [CNT_W-1:0]  sc_q, nsteps_q;
  op_e               last_op, seq_op;
  logic              start, eng_run, eng_done, wr_ok, is_md, is_ctl;
  logic [WORD_W-1:0] opa, res_w;
  logic [HALF_W-1:0] opb, res_h;
  logic [STEP_W-1:0] steps;
  logic              unused_bits;

  assign unused_bits = ^wdata[7:6];

  function automatic logic [STEP_W-1:0] lead0(input logic [WORD_W-1:0] v);
    lead0 = STEP_W'(WORD_W - 1);
    for (int i = 0; i < WORD_W; i++)
      if (v[i]) lead0 = STEP_W'(WORD_W - 1 - i);
  endfunction

  assign busy   = start | eng_run | eng_done;
  assign wr_ok  = wr_en & ~busy;
  assign is_md  = addr < ADDR_W'(NREG);
  assign is_ctl = addr == ADDR_W'(IDX_CTRL);

  always_comb begin
    for (int i = 0; i < WBYTES; i++) opa[i*BYTE_W +: BYTE_W] = md[i];
    for (int i = 0; i < HBYTES; i++) opb[i*BYTE_W +: BYTE_W] = md[WBYTES+i];
    case (seq_op)
      OP_DIV:   steps = STEP_W'(WORD_W);
      OP_MUL:   steps = STEP_W'(HALF_W);
      OP_SHIFT: steps = STEP_W'(sc_q);
      OP_NORM:  steps = lead0(opa);
      default:  steps = '0;
    endcase
  end

  arith_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .idx      (addr),
    .cnt_zero (wdata[CNT_W-1:0] == '0),
    .start    (start),
    .op       (seq_op)
  );

  arith_engine u_eng (
    .clk   (clk),
    .rst   (rst),
    .load  (start),
    .op    (seq_op),
    .dir   (dir_q),
    .a     (opa),
    .b     (opb),
    .steps (steps),
    .run   (eng_run),
    .done  (eng_done),
    .res_w (res_w),
    .res_h (res_h)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) md[i] <= '0;
      err_q    <= 1'b0;
      ovf_q    <= 1'b0;
      dir_q    <= 1'b0;
      sc_q     <= '0;
      nsteps_q <= '0;
      armed_q  <= 1'b0;
      last_op  <= OP_NONE;
      rdata    <= '0;
    end else begin
      if (wr_ok) begin
        if (is_md)  md[addr] <= wdata;
        if (is_ctl) {dir_q, sc_q} <= wdata[CNT_W:0];
        if (addr == '0) begin
          ovf_q   <= 1'b0;
          armed_q <= 1'b1;
        end
      end
      if (wr_en && busy && is_md && armed_q) err_q <= 1'b1;
      if (start) begin
        last_op  <= seq_op;
        nsteps_q <= steps[CNT_W-1:0];
        if (seq_op == OP_DIV && opb == '0)              ovf_q <= 1'b1;
        if (seq_op == OP_NORM && md[WBYTES-1][BYTE_W-1]) ovf_q <= 1'b1;
      end
      if (eng_done) begin
        for (int i = 0; i < WBYTES; i++) md[i] <= res_w[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < HBYTES; i++) md[WBYTES+i] <= res_h[i*BYTE_W +: BYTE_W];
        if (last_op == OP_MUL && res_w[WORD_W-1:HALF_W] != '0) ovf_q <= 1'b1;
        if (last_op == OP_NORM) sc_q <= nsteps_q;
      end
      if (rd_en) begin
        if (is_ctl)     rdata <= {err_q, ovf_q, dir_q, sc_q};
        else if (is_md) rdata <= md[addr];
        else            rdata <= '0;
        if (is_md && !busy) begin
          err_q <= 1'b0;
          if (addr == ADDR_W'(last_op == OP_DIV ? IDX_DLAST : IDX_MLAST))
            armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/arith_copro_chk.sv
module arith_copro_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              armed_q,
  input logic              err_q,
  input logic              ovf_q
);
  // R9: an operand write during a calculation raises the error flag
  a_r9_err_on_busy_write: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr < ADDR_W'(6) && armed_q) |=> err_q);

  // R10: an idle operand read clears the error flag
  a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
    (!busy && rd_en && addr < ADDR_W'(6)) |=> !err_q);

  // R11: an idle write to byte 0 clears the overflow flag
  a_r11_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && addr == '0) |=> !ovf_q);

  // R13: busy only rises after a bus write
  a_r13_busy_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));

  // R12: with no operation in flight and no write, overflow holds
  a_r12_idle_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_en) |=> $stable(ovf_q));
endmodule

bind arith_copro arith_copro_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .busy    (busy),
  .armed_q (armed_q),
  .err_q   (err_q),
  .ovf_q   (ovf_q)
);

// File: tb/arith_copro_tb.sv
`timescale 1ns/1ps
module arith_copro_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  arith_copro u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  // {kind(0 div,1 mul,2 shift/normalize), a[31:0], b[15:0], ctl[5:0]}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {2'd0, 32'h000F4240, 16'h0007, 6'd0},
    {2'd0, 32'hFFFFFFFF, 16'hFFFF, 6'd0},
    {2'd0, 32'h12345678, 16'h0000, 6'd0},
    {2'd0, 32'h00000005, 16'h1234, 6'd0},
    {2'd1, 32'h000004D2, 16'h162E, 6'd0},
    {2'd1, 32'h000000FF, 16'h0100, 6'd0},
    {2'd1, 32'h0000FFFF, 16'hFFFF, 6'd0},
    {2'd2, 32'h00001234, 16'h0000, 6'b000100},
    {2'd2, 32'h80000001, 16'h0000, 6'b101000},
    {2'd2, 32'h00010000, 16'h0000, 6'b000000},
    {2'd2, 32'h00000000, 16'h0000, 6'b000000},
    {2'd2, 32'h80000000, 16'h0000, 6'b000000},
    {2'd2, 32'hFFFFFFFF, 16'h0000, 6'b111111}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 200) begin
      @(posedge clk); #1;
      g++;
    end
  endtask

  task automatic launch(input logic [55:0] v);
    logic [31:0] a = v[53:22];
    logic [15:0] b = v[21:6];
    case (v[55:54])
      2'd0: begin
        for (int i = 0; i < 4; i++) wr(3'(i), a[i*8 +: 8]);
        wr(3'd4, b[7:0]); wr(3'd5, b[15:8]);
      end
      2'd1: begin
        wr(3'd0, a[7:0]); wr(3'd4, b[7:0]); wr(3'd1, a[15:8]); wr(3'd5, b[15:8]);
      end
      default: begin
        for (int i = 0; i < 4; i++) wr(3'(i), a[i*8 +: 8]);
        wr(3'd6, {2'b00, v[5:0]});
      end
    endcase
  endtask

  task automatic run_vec(input logic [55:0] v);
    logic [1:0]  k = v[55:54];
    logic [31:0] a = v[53:22];
    logic [15:0] b = v[21:6];
    logic [5:0]  c = v[5:0];
    logic [31:0] expw, got;
    logic [15:0] exph;
    logic [7:0]  lo, hi, cr;
    logic [5:0]  ectl;
    logic        eovf;
    int          steps, cyc, lz;
    string       tg;
    ectl = c;
    if (k == 2'd0) begin
      steps = 32;
      eovf = (b == 16'h0);
      tg = eovf ? "R3" : "R2";
      expw = eovf ? 32'hFFFFFFFF : a / {16'h0, b};
      exph = eovf ? a[15:0] : 16'(a % {16'h0, b});
    end else if (k == 2'd1) begin
      steps = 16;
      expw = {16'h0, a[15:0]} * {16'h0, b};
      exph = b;
      eovf = expw[31:16] != 16'h0;
      tg = eovf ? "R5" : "R4";
    end else if (c[4:0] != 5'd0) begin
      steps = int'(c[4:0]);
      expw = c[5] ? (a >> c[4:0]) : (a << c[4:0]);
      exph = '0;
      eovf = 1'b0;
      tg = "R6";
    end else begin
      lz = 31;
      for (int i = 0; i < 32; i++) if (a[i]) lz = 31 - i;
      steps = lz;
      expw = a << lz;
      exph = '0;
      eovf = a[31];
      ectl = {c[5], 5'(lz)};
      tg = eovf ? "R8" : "R7";
    end
    launch(v);
    chk(busy === 1'b1, "R12 busy after launch", {31'h0, busy}, 32'h1);
    cyc = 0;
    while (busy && cyc < 100) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk(cyc == steps + 2, "R12 busy length", cyc, steps + 2);
    rd32(got);
    chk(got == expw, {tg, " result"}, got, expw);
    if (k != 2'd2) begin
      rd(3'd4, lo); rd(3'd5, hi);
      chk({hi, lo} == exph, {tg, " upper bytes"}, {16'h0, hi, lo}, {16'h0, exph});
    end
    rd(3'd6, cr);
    chk(cr[7:6] == {1'b0, eovf}, {tg, " flags"}, {30'h0, cr[7:6]}, {31'h0, eovf});
    if (k == 2'd2) chk(cr[5:0] == ectl, {tg, " control field"}, {26'h0, cr[5:0]}, {26'h0, ectl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1: reset state
    chk(busy === 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), d);
      chk(d == 8'h00, "R1 register reset", {24'h0, d}, 32'h0);
    end

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // R11: overflow from a divide by zero, then cleared by a byte 0 write
    run_vec(VEC[2]);
    wr(3'd0, 8'h00);
    rd(3'd6, d);
    chk(d[6] == 1'b0, "R11 overflow cleared", {31'h0, d[6]}, 32'h0);

    // R9: write while busy sets error and is discarded
    launch(VEC[0]);
    wr(3'd2, 8'hAA);
    wait_idle();
    rd(3'd6, d);
    chk(d[7] == 1'b1, "R9 error set", {31'h0, d[7]}, 32'h1);
    rd32(q);
    chk(q == 32'd142857, "R9 result unaffected", q, 32'd142857);
    // R10: operand read after completion cleared the error flag
    rd(3'd6, d);
    chk(d[7] == 1'b0, "R10 error cleared", {31'h0, d[7]}, 32'h0);
    // R10: flag bits cannot be written; R13: idle control write starts nothing
    wr(3'd6, 8'hC0);
    chk(busy === 1'b0, "R13 lone control write", {31'h0, busy}, 32'h0);
    rd(3'd6, d);
    chk(d == 8'h00, "R10 flags read-only", {24'h0, d}, 32'h0);

    // R13: out-of-order writes store data but launch nothing
    wr(3'd0, 8'h11); wr(3'd2, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    chk(busy === 1'b0, "R13 no launch", {31'h0, busy}, 32'h0);
    rd(3'd2, d);
    chk(d == 8'h22, "R13 byte 2 stored", {24'h0, d}, 32'h22);
    rd(3'd5, d);
    chk(d == 8'h44, "R13 byte 5 stored", {24'h0, d}, 32'h44);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule